// File: doc/BRIEF.md
# Branch Target and History Predictor

This block sits in the fetch stage. Each cycle it looks up the instruction PC in two tables. One is a tagged target table that stores the full branch PC and its last taken destination. The other is an untagged table of 2-bit saturating counters. In the same cycle, with no register on the path, it reports three things: whether the PC is a known branch, a taken/not-taken guess, and the PC to fetch next.

Both tables are trained only when a branch resolves. The resolving stage presents the branch PC, its real direction and its real destination on the update port. The counter at that PC's index is stepped up or down. A taken branch also writes its PC and destination into the target table. Fetch lookups never change either table.

Top module: `branch_predictor`

## Requirements
- R1: After reset no target entry is valid and every counter holds the reset value (default 00). A lookup then gives hit_o=0, taken_o=0 and next_pc_o equal to the fetch PC plus 4.
- R2: hit_o is 1 only when the target entry at index PC[5:2] is valid and its stored PC equals the full fetch PC. Another PC that maps to the same index (0x140 against 0x100) misses.
- R3: next_pc_o equals the stored target when hit_o=1 and the counter's upper bit is 1. In every other case it equals the fetch PC plus 4. taken_o is the counter's upper bit.
- R4: Counter encoding: 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. A taken update adds one and stops at 11.
- R5: A not-taken update subtracts one and stops at 00.
- R6: Lookups alone never change a counter or a target entry.
- R7: A taken update writes the branch PC and target into the target entry and sets its valid bit. A not-taken update leaves the target table unchanged.
- R8: The counter table has 8 entries, indexed by PC[4:2], with no tag. PCs that share those bits share a counter, whether or not they hit in the target table.
- R9: When an update and a lookup reach the same index in one cycle, the lookup reports the contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | 32 | PC being fetched |
| hit_o | output | 1 | The fetch PC matches a valid target entry |
| taken_o | output | 1 | Direction guess (upper bit of the counter) |
| next_pc_o | output | 32 | Predicted next fetch PC |
| upd_valid_i | input | 1 | A resolved branch is presented this cycle |
| upd_pc_i | input | 32 | PC of the resolved branch |
| upd_taken_i | input | 1 | Real direction of the resolved branch |
| upd_target_i | input | 32 | Real destination of the resolved branch |

## Verification
The assertions check these rules on every cycle:
- Neither table changes in a cycle with no update.
- A taken update always leaves its target entry valid.
- A counter at 11 stays at 11 on a taken update, and a counter at 00 stays at 00 on a not-taken update.
- next_pc_o leaves PC plus 4 only on a hit with a taken guess.

Some behaviours need the bench's directed scenarios:
- the exact counter sequence through all four states;
- a miss on a PC that shares an index with a stored branch;
- counter sharing between PCs that alias in the history table;
- the old contents seen by a lookup in the same cycle as an update.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] cnt_t;
  localparam cnt_t CNT_MAX = 2'b11;
  localparam cnt_t CNT_MIN = 2'b00;

  function automatic cnt_t cnt_step(cnt_t c, logic up);
    if (up) return (c == CNT_MAX) ? c : c + 2'd1;
    else    return (c == CNT_MIN) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/bp_target_table.sv
module bp_target_table #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int ALIGN = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic            hit_o,
  output logic [PC_W-1:0] tgt_o,
  input  logic            wr_i,
  input  logic [PC_W-1:0] wr_pc_i,
  input  logic [PC_W-1:0] wr_tgt_i
);
  localparam int N = 1 << IDX_W;

  logic [N-1:0]           valid_q;
  logic [N-1:0][PC_W-1:0] tag_q;
  logic [N-1:0][PC_W-1:0] tgt_q;
  logic [IDX_W-1:0]       lk_idx, wr_idx;

  assign lk_idx = lk_pc_i[ALIGN +: IDX_W];
  assign wr_idx = wr_pc_i[ALIGN +: IDX_W];

  // full-PC compare: a wrong target must never be used
  assign hit_o = valid_q[lk_idx] && (tag_q[lk_idx] == lk_pc_i);
  assign tgt_o = tgt_q[lk_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
      tgt_q   <= '0;
    end else if (wr_i) begin
      valid_q[wr_idx] <= 1'b1;
      tag_q[wr_idx]   <= wr_pc_i;
      tgt_q[wr_idx]   <= wr_tgt_i;
    end
  end

  // R7
  wr_sets_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> valid_q[$past(wr_idx)]);
  // R6
  no_wr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(valid_q) && $stable(tag_q) && $stable(tgt_q)));
endmodule

// File: rtl/bp_history_table.sv
module bp_history_table
  import bp_pkg::*;
#(
  parameter int   PC_W     = 32,
  parameter int   IDX_W    = 3,
  parameter int   ALIGN    = 2,
  parameter cnt_t CNT_INIT = 2'b00
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic            taken_o,
  input  logic            upd_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i
);
  localparam int N = 1 << IDX_W;

  logic [N-1:0][1:0] cnt_q;
  logic [IDX_W-1:0]  lk_idx, upd_idx;

  assign lk_idx  = lk_pc_i[ALIGN +: IDX_W];
  assign upd_idx = upd_pc_i[ALIGN +: IDX_W];
  assign taken_o = cnt_q[lk_idx][1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) cnt_q[i] <= CNT_INIT;
    end else if (upd_i) begin
      cnt_q[upd_idx] <= cnt_step(cnt_q[upd_idx], upd_taken_i);
    end
  end

  // R4
  sat_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && upd_taken_i && cnt_q[upd_idx] == 2'b11) |=> cnt_q[$past(upd_idx)] == 2'b11);
  // R5
  sat_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !upd_taken_i && cnt_q[upd_idx] == 2'b00) |=> cnt_q[$past(upd_idx)] == 2'b00);
  // R6
  lookup_no_train_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(cnt_q));
endmodule

// File: rtl/branch_predictor.sv
module branch_predictor #(
  parameter int         PC_W     = 32,
  parameter int         BTB_IDX  = 4,
  parameter int         BHT_IDX  = 3,
  parameter int         ALIGN    = 2,
  parameter logic [1:0] CNT_INIT = 2'b00
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic            hit_o,
  output logic            taken_o,
  output logic [PC_W-1:0] next_pc_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic [PC_W-1:0] upd_target_i
);
  localparam logic [PC_W-1:0] STEP = PC_W'(1 << ALIGN);

  logic [PC_W-1:0] tgt;
  logic [PC_W-1:0] seq_pc;

  bp_target_table #(.PC_W(PC_W), .IDX_W(BTB_IDX), .ALIGN(ALIGN)) u_btb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lk_pc_i  (fetch_pc_i),
    .hit_o    (hit_o),
    .tgt_o    (tgt),
    .wr_i     (upd_valid_i && upd_taken_i),
    .wr_pc_i  (upd_pc_i),
    .wr_tgt_i (upd_target_i)
  );

  bp_history_table #(.PC_W(PC_W), .IDX_W(BHT_IDX), .ALIGN(ALIGN), .CNT_INIT(CNT_INIT)) u_bht (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_pc_i     (fetch_pc_i),
    .taken_o     (taken_o),
    .upd_i       (upd_valid_i),
    .upd_pc_i    (upd_pc_i),
    .upd_taken_i (upd_taken_i)
  );

  assign seq_pc    = fetch_pc_i + STEP;
  assign next_pc_o = (hit_o && taken_o) ? tgt : seq_pc;

  // R3
  redirect_only_on_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (next_pc_o != fetch_pc_i + STEP) |-> (hit_o && taken_o));
endmodule

// File: tb/tb_branch_predictor.sv
module tb_branch_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        hit, taken;
  logic [31:0] next_pc;
  logic        upd_v = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_t = 1'b0;
  logic [31:0] upd_tgt = '0;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  branch_predictor dut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_pc_i(fetch_pc),
    .hit_o(hit), .taken_o(taken), .next_pc_o(next_pc),
    .upd_valid_i(upd_v), .upd_pc_i(upd_pc), .upd_taken_i(upd_t), .upd_target_i(upd_tgt)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic update(logic [31:0] pc, logic t, logic [31:0] tg);
    @(negedge clk);
    upd_v = 1'b1; upd_pc = pc; upd_t = t; upd_tgt = tg;
    @(negedge clk);
    upd_v = 1'b0;
  endtask

  task automatic look(logic [31:0] pc, logic eh, logic et, logic [31:0] enp, string req);
    fetch_pc = pc;
    #1;
    chk({req, " hit"}, 32'(hit), 32'(eh));
    chk({req, " taken"}, 32'(taken), 32'(et));
    chk({req, " next_pc"}, next_pc, enp);
  endtask

  task automatic t_reset;
    look(32'h100, 0, 0, 32'h104, "R1");
    look(32'h11c, 0, 0, 32'h120, "R1");
  endtask

  task automatic t_train_up;
    update(32'h100, 1, 32'h200);            // 00->01
    look(32'h100, 1, 0, 32'h104, "R3 hit weak-nt");
    update(32'h100, 1, 32'h200);            // 10
    look(32'h100, 1, 1, 32'h200, "R7 R3 redirect");
    update(32'h100, 1, 32'h200);            // 11
    update(32'h100, 1, 32'h200);            // stays 11
    update(32'h100, 0, 32'h0);              // 10, target untouched
    look(32'h100, 1, 1, 32'h200, "R4 saturate R7 nt keeps entry");
  endtask

  task automatic t_train_down;
    update(32'h100, 0, 32'h0);              // 01
    look(32'h100, 1, 0, 32'h104, "R5 step down");
    update(32'h100, 0, 32'h0);              // 00
    update(32'h100, 0, 32'h0);              // stays 00
    update(32'h100, 1, 32'h200);            // 01
    look(32'h100, 1, 0, 32'h104, "R5 saturate low");
    update(32'h100, 1, 32'h200);            // 10
    look(32'h100, 1, 1, 32'h200, "R4 back to taken");
  endtask

  task automatic t_alias;
    // 0x140 shares target index and counter index with 0x100
    look(32'h140, 0, 1, 32'h144, "R2 R8 alias");
    update(32'h140, 0, 32'h0);              // shared counter -> 01
    look(32'h100, 1, 0, 32'h104, "R8 shared counter");
    update(32'h100, 1, 32'h200);            // back to 10
  endtask

  task automatic t_lookup_only;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      fetch_pc = 32'h100 + 32'(i * 4);
    end
    @(negedge clk);
    look(32'h100, 1, 1, 32'h200, "R6 lookups leave state");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    upd_v = 1'b1; upd_pc = 32'h110; upd_t = 1'b1; upd_tgt = 32'h300;
    look(32'h110, 0, 0, 32'h114, "R9 old contents");
    @(negedge clk);
    upd_v = 1'b0;
    look(32'h110, 1, 0, 32'h114, "R9 after write");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_train_up();
    t_train_down();
    t_alias();
    t_lookup_only();
    t_same_cycle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule